// File: doc/BRIEF.md
# Co-processor Mailbox and Control Register Block

This block is a memory-mapped register file on a 32-bit bus. It sits between a host CPU and an embedded co-processor. It holds three things. A control register keeps the co-processor in reset and gates its clock. Two mailbox registers carry traffic, one for each direction. A 16-word message RAM holds a checksummed five-word message. The host writes a command into the message RAM and then rings the doorbell by writing a nonzero value to the co-processor mailbox. The co-processor replies with a nonzero result code in the host mailbox. The host then writes that mailbox back to zero to close the exchange.

A second port gives the co-processor the same address map. It has its own write strobe and its own registered read path. While the co-processor is held in reset, its writes are dropped. The host can start a built-in start-up sequence by writing the start bit of the control register. The sequence clears both mailboxes first, then removes the clock gate, then releases reset, each step on its own clock cycle.

Two status outputs look at the message area. The first reports whether the checksum word (word 4) equals the 32-bit sum of words 0 to 3. The second flags a response whose location word carries a memory type other than message RAM or data RAM.

Top module: `cpmbx_regs`

## Requirements
- R1: After synchronous reset, the control register reads 0x5, both mailboxes and all message RAM words read 0, cp_reset and cp_clk_gate are 1, and doorbell_pending is 0.
- R2: A read strobe on either port returns the addressed word on that port's read data output one cycle later. The output holds its value when no read is strobed. The word map, taken from the byte address with bits [1:0] ignored, is: control at 0x00, co-processor mailbox at 0x10, host mailbox at 0x14, message word i at 0x100+4*i.
- R3: A host write to the control register, with bit 8 clear, loads bit 0 into cp_reset and bit 2 into cp_clk_gate. Bits other than 0 and 2 read back as 0.
- R4: All 16 message RAM words can be written and read from both ports, and each port sees the other port's data.
- R5: When both ports write the same location in the same cycle, the host value is stored.
- R6: While cp_reset is 1, writes from the co-processor port change no location. Reads from that port still work.
- R7: doorbell_pending is 1 exactly while the co-processor mailbox holds a nonzero value.
- R8: cmd_checksum_ok is 1 exactly when message word 4 equals the modulo-2^32 sum of message words 0, 1, 2 and 3.
- R9: resp_loc_fatal is 1 exactly when message word 0 equals 2 (response type) and bits [31:28] of message word 3 are neither 0 (data RAM) nor 1 (message RAM).
- R10: A host write to the control register with bit 8 set starts the start-up sequence. The other bits of that write are ignored. On the first clock edge after the write, both mailboxes clear. On the second edge, cp_clk_gate falls. On the third edge, cp_reset falls. Control register writes made during the sequence are ignored.
- R11: Addresses outside the map read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe, single cycle |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Host read data, registered |
| c_wr | input | 1 | Co-processor write strobe |
| c_rd | input | 1 | Co-processor read strobe |
| c_addr | input | ADDR_W | Co-processor byte address |
| c_wdata | input | DATA_W | Co-processor write data |
| c_rdata | output | DATA_W | Co-processor read data, registered |
| cp_reset | output | 1 | Holds the co-processor in reset |
| cp_clk_gate | output | 1 | Gates off the co-processor clock |
| doorbell_pending | output | 1 | Co-processor mailbox is nonzero |
| cmd_checksum_ok | output | 1 | Message checksum word matches |
| resp_loc_fatal | output | 1 | Response location type is invalid |

## Verification
The assertions assume that the strobes are 0 or 1 on every clock edge and that reset is held for at least one edge before the first access. The blocked-write property also assumes that an ignored co-processor write is not shadowed by a host write or a sequence clear in the same cycle. The stimulus drives every input on the falling edge from tasks, one access per port per cycle. It makes simultaneous writes on both ports only in the collision case, and it makes a control write during the start-up sequence only in the step that checks that such a write is ignored.

// File: rtl/cpmbx_pkg.sv
package cpmbx_pkg;
  // Word indices (byte address >> 2) of the fixed registers
  localparam int unsigned CTRL_WORD     = 0;
  localparam int unsigned TOCP_WORD     = 4;
  localparam int unsigned TOHOST_WORD   = 5;
  localparam int unsigned MSG_BASE_WORD = 64;

  // Control register bit positions
  localparam int unsigned CTRL_HOLD_BIT  = 0;
  localparam int unsigned CTRL_GATE_BIT  = 2;
  localparam int unsigned CTRL_START_BIT = 8;

  // Message header and location type codes
  localparam int unsigned HDR_RESPONSE = 2;
  localparam int unsigned LOC_TYPE_W   = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_CLR_MBX,
    SEQ_CLR_GATE,
    SEQ_RELEASE
  } seq_state_e;
endpackage

// File: rtl/cpmbx_decode.sv
module cpmbx_decode #(
  parameter int ADDR_W    = 12,
  parameter int MSG_WORDS = 16,
  localparam int IDX_W    = $clog2(MSG_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_ctrl,
  output logic              is_tocp,
  output logic              is_tohost,
  output logic              is_msg,
  output logic [IDX_W-1:0]  msg_idx
);
  import cpmbx_pkg::*;

  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] rel;

  always_comb begin
    waddr     = addr >> 2;
    rel       = waddr - ADDR_W'(MSG_BASE_WORD);
    is_ctrl   = (waddr == ADDR_W'(CTRL_WORD));
    is_tocp   = (waddr == ADDR_W'(TOCP_WORD));
    is_tohost = (waddr == ADDR_W'(TOHOST_WORD));
    is_msg    = (rel < ADDR_W'(MSG_WORDS));
    msg_idx   = rel[IDX_W-1:0];
  end
endmodule

// File: rtl/cpmbx_msg_ram.sv
module cpmbx_msg_ram #(
  parameter int DATA_W    = 32,
  parameter int MSG_WORDS = 16,
  localparam int IDX_W    = $clog2(MSG_WORDS)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              a_we,
  input  logic [IDX_W-1:0]                  a_idx,
  input  logic [DATA_W-1:0]                 a_wdata,
  input  logic                              b_we,
  input  logic [IDX_W-1:0]                  b_idx,
  input  logic [DATA_W-1:0]                 b_wdata,
  output logic [MSG_WORDS-1:0][DATA_W-1:0]  words_o
);
  // Port a (host) has priority over port b (co-processor)
  for (genvar i = 0; i < MSG_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        words_o[i] <= '0;
      else if (a_we && a_idx == IDX_W'(i))
        words_o[i] <= a_wdata;
      else if (b_we && b_idx == IDX_W'(i))
        words_o[i] <= b_wdata;
    end
  end
endmodule

// File: rtl/cpmbx_enable_seq.sv
module cpmbx_enable_seq (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic clr_mbx_o,
  output logic clr_gate_o,
  output logic clr_hold_o
);
  import cpmbx_pkg::*;

  seq_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
    end else begin
      unique case (state_q)
        SEQ_IDLE:     if (start_i) state_q <= SEQ_CLR_MBX;
        SEQ_CLR_MBX:  state_q <= SEQ_CLR_GATE;
        SEQ_CLR_GATE: state_q <= SEQ_RELEASE;
        SEQ_RELEASE:  state_q <= SEQ_IDLE;
        default:      state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    busy_o     = (state_q != SEQ_IDLE);
    clr_mbx_o  = (state_q == SEQ_CLR_MBX);
    clr_gate_o = (state_q == SEQ_CLR_GATE);
    clr_hold_o = (state_q == SEQ_RELEASE);
  end
endmodule

// File: rtl/cpmbx_msg_check.sv
module cpmbx_msg_check #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] hdr_w,
  input  logic [DATA_W-1:0] cmd_w,
  input  logic [DATA_W-1:0] argc_w,
  input  logic [DATA_W-1:0] arg_w,
  input  logic [DATA_W-1:0] sum_w,
  output logic              sum_ok,
  output logic              loc_fatal
);
  import cpmbx_pkg::*;

  logic [DATA_W-1:0]     total;
  logic [LOC_TYPE_W-1:0] loc_type;

  always_comb begin
    total     = hdr_w + cmd_w + argc_w + arg_w;
    sum_ok    = (total == sum_w);
    loc_type  = arg_w[DATA_W-1 -: LOC_TYPE_W];
    loc_fatal = (hdr_w == DATA_W'(HDR_RESPONSE)) && (loc_type > LOC_TYPE_W'(1));
  end
endmodule

// File: rtl/cpmbx_regs.sv
module cpmbx_regs #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int MSG_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              c_wr,
  input  logic              c_rd,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_wdata,
  output logic [DATA_W-1:0] c_rdata,
  output logic              cp_reset,
  output logic              cp_clk_gate,
  output logic              doorbell_pending,
  output logic              cmd_checksum_ok,
  output logic              resp_loc_fatal
);
  import cpmbx_pkg::*;

  localparam int IDX_W  = $clog2(MSG_WORDS);
  localparam int NPORTS = 2;  // 0: host, 1: co-processor

  logic                             hold_q, gate_q;
  logic [DATA_W-1:0]                tocp_q, tohost_q;
  logic [MSG_WORDS-1:0][DATA_W-1:0] msg_words;
  logic                             seq_busy, clr_mbx, clr_gate, clr_hold;
  logic                             seq_start, h_ctrl_wr, c_wr_eff;

  logic [NPORTS-1:0]                p_rd;
  logic [NPORTS-1:0][ADDR_W-1:0]    p_addr;
  logic [NPORTS-1:0][DATA_W-1:0]    p_rdata;
  logic [NPORTS-1:0]                p_ctrl, p_tocp, p_tohost, p_msg;
  logic [NPORTS-1:0][IDX_W-1:0]     p_idx;

  assign p_rd   = {c_rd, h_rd};
  assign p_addr = {c_addr, h_addr};

  // Per-port decode and registered read path
  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    logic [DATA_W-1:0] rd_mux;

    cpmbx_decode #(.ADDR_W(ADDR_W), .MSG_WORDS(MSG_WORDS)) u_dec (
      .addr      (p_addr[g]),
      .is_ctrl   (p_ctrl[g]),
      .is_tocp   (p_tocp[g]),
      .is_tohost (p_tohost[g]),
      .is_msg    (p_msg[g]),
      .msg_idx   (p_idx[g])
    );

    always_comb begin
      rd_mux = '0;
      if (p_ctrl[g]) begin
        rd_mux[CTRL_HOLD_BIT] = hold_q;
        rd_mux[CTRL_GATE_BIT] = gate_q;
      end else if (p_tocp[g]) begin
        rd_mux = tocp_q;
      end else if (p_tohost[g]) begin
        rd_mux = tohost_q;
      end else if (p_msg[g]) begin
        rd_mux = msg_words[p_idx[g]];
      end
    end

    always_ff @(posedge clk) begin
      if (rst)
        p_rdata[g] <= '0;
      else if (p_rd[g])
        p_rdata[g] <= rd_mux;
    end
  end

  assign h_rdata = p_rdata[0];
  assign c_rdata = p_rdata[1];

  // Write qualification
  assign c_wr_eff  = c_wr && !hold_q;
  assign h_ctrl_wr = h_wr && p_ctrl[0] && !seq_busy;
  assign seq_start = h_ctrl_wr && h_wdata[CTRL_START_BIT];

  cpmbx_enable_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (seq_start),
    .busy_o     (seq_busy),
    .clr_mbx_o  (clr_mbx),
    .clr_gate_o (clr_gate),
    .clr_hold_o (clr_hold)
  );

  // Control register
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b1;
      gate_q <= 1'b1;
    end else begin
      if (h_ctrl_wr && !h_wdata[CTRL_START_BIT]) begin
        hold_q <= h_wdata[CTRL_HOLD_BIT];
        gate_q <= h_wdata[CTRL_GATE_BIT];
      end
      if (clr_gate) gate_q <= 1'b0;
      if (clr_hold) hold_q <= 1'b0;
    end
  end

  // Mailboxes: sequence clear, then host, then co-processor
  always_ff @(posedge clk) begin
    if (rst) begin
      tocp_q   <= '0;
      tohost_q <= '0;
    end else if (clr_mbx) begin
      tocp_q   <= '0;
      tohost_q <= '0;
    end else begin
      if (h_wr && p_tocp[0])          tocp_q <= h_wdata;
      else if (c_wr_eff && p_tocp[1]) tocp_q <= c_wdata;
      if (h_wr && p_tohost[0])          tohost_q <= h_wdata;
      else if (c_wr_eff && p_tohost[1]) tohost_q <= c_wdata;
    end
  end

  cpmbx_msg_ram #(.DATA_W(DATA_W), .MSG_WORDS(MSG_WORDS)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .a_we    (h_wr && p_msg[0]),
    .a_idx   (p_idx[0]),
    .a_wdata (h_wdata),
    .b_we    (c_wr_eff && p_msg[1]),
    .b_idx   (p_idx[1]),
    .b_wdata (c_wdata),
    .words_o (msg_words)
  );

  cpmbx_msg_check #(.DATA_W(DATA_W)) u_chk (
    .hdr_w     (msg_words[0]),
    .cmd_w     (msg_words[1]),
    .argc_w    (msg_words[2]),
    .arg_w     (msg_words[3]),
    .sum_w     (msg_words[4]),
    .sum_ok    (cmd_checksum_ok),
    .loc_fatal (resp_loc_fatal)
  );

  assign cp_reset         = hold_q;
  assign cp_clk_gate      = gate_q;
  assign doorbell_pending = |tocp_q;
endmodule

// File: rtl/cpmbx_regs_sva.sv
module cpmbx_regs_sva #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              h_wr,
  input logic              h_rd,
  input logic [DATA_W-1:0] h_rdata,
  input logic              c_wr,
  input logic [ADDR_W-1:0] c_addr,
  input logic              cp_reset,
  input logic              cp_clk_gate,
  input logic              doorbell_pending,
  input logic              seq_busy,
  input logic [DATA_W-1:0] tohost_q
);
  // R1: the first cycle out of reset leaves the co-processor held and gated
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cp_reset && cp_clk_gate && !doorbell_pending));

  // R2: read data changes only after a read strobe
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(h_rd)) |-> $stable(h_rdata));

  // R6: a co-processor write to the host mailbox while held in reset is dropped
  p_cp_blocked_r6: assert property (@(posedge clk) disable iff (rst)
    (c_wr && cp_reset && !h_wr && !seq_busy && (c_addr >> 2) == ADDR_W'(5))
    |=> $stable(tohost_q));

  // R7: the doorbell rises only after a write on one of the ports
  p_doorbell_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(doorbell_pending) |-> $past(h_wr || c_wr));

  // R10: a release from the sequence finds the clock already ungated
  p_gate_before_run_r10: assert property (@(posedge clk) disable iff (rst)
    ($fell(cp_reset) && $past(seq_busy)) |-> (!cp_clk_gate && $past(!cp_clk_gate)));
endmodule

bind cpmbx_regs cpmbx_regs_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
  .clk              (clk),
  .rst              (rst),
  .h_wr             (h_wr),
  .h_rd             (h_rd),
  .h_rdata          (h_rdata),
  .c_wr             (c_wr),
  .c_addr           (c_addr),
  .cp_reset         (cp_reset),
  .cp_clk_gate      (cp_clk_gate),
  .doorbell_pending (doorbell_pending),
  .seq_busy         (seq_busy),
  .tohost_q         (tohost_q)
);

// File: tb/cpmbx_regs_tb.sv
module cpmbx_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int MSG_WORDS = 16;
  localparam logic [11:0] A_CTRL = 12'h000;
  localparam logic [11:0] A_TOCP = 12'h010;
  localparam logic [11:0] A_TOHOST = 12'h014;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic h_wr = 0, h_rd = 0, c_wr = 0, c_rd = 0;
  logic [ADDR_W-1:0] h_addr = '0, c_addr = '0;
  logic [DATA_W-1:0] h_wdata = '0, c_wdata = '0;
  logic [DATA_W-1:0] h_rdata, c_rdata;
  logic cp_reset, cp_clk_gate, doorbell_pending, cmd_checksum_ok, resp_loc_fatal;

  int checks = 0;
  int failures = 0;
  logic [DATA_W-1:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpmbx_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MSG_WORDS(MSG_WORDS)) u_dut (
    .clk(clk), .rst(rst),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .c_wr(c_wr), .c_rd(c_rd), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
    .cp_reset(cp_reset), .cp_clk_gate(cp_clk_gate), .doorbell_pending(doorbell_pending),
    .cmd_checksum_ok(cmd_checksum_ok), .resp_loc_fatal(resp_loc_fatal)
  );

  function automatic logic [11:0] msg_addr(int i);
    return 12'h100 + 12'(4 * i);
  endfunction

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk); h_wr = 1; h_addr = a; h_wdata = d;
    @(negedge clk); h_wr = 0;
  endtask

  task automatic cwrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk); c_wr = 1; c_addr = a; c_wdata = d;
    @(negedge clk); c_wr = 0;
  endtask

  task automatic bothwrite(logic [11:0] a, logic [31:0] hd, logic [31:0] cd);
    @(negedge clk); h_wr = 1; h_addr = a; h_wdata = hd; c_wr = 1; c_addr = a; c_wdata = cd;
    @(negedge clk); h_wr = 0; c_wr = 0;
  endtask

  task automatic hread(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); h_rd = 1; h_addr = a;
    @(negedge clk); h_rd = 0; d = h_rdata;
  endtask

  task automatic cread(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); c_rd = 1; c_addr = a;
    @(negedge clk); c_rd = 0; d = c_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: reset state
    check("R1 cp_reset", 32'(cp_reset), 1);
    check("R1 cp_clk_gate", 32'(cp_clk_gate), 1);
    check("R1 doorbell", 32'(doorbell_pending), 0);
    hread(A_CTRL, rv);   check("R1 ctrl", rv, 32'h5);
    hread(A_TOCP, rv);   check("R1 tocp", rv, 0);
    hread(A_TOHOST, rv); check("R1 tohost", rv, 0);
    for (int i = 0; i < MSG_WORDS; i++) begin
      hread(msg_addr(i), rv); check("R1 msg word", rv, 0);
    end

    // R2: read data holds without a strobe
    hwrite(msg_addr(0), 32'h1234_5678);
    hread(msg_addr(0), rv);
    @(negedge clk); @(negedge clk);
    check("R2 hold", h_rdata, 32'h1234_5678);
    hwrite(msg_addr(0), 32'h0);

    // R11: unmapped locations
    hwrite(12'h020, 32'hFFFF_FFFF);
    hread(12'h020, rv); check("R11 unmapped 0x20", rv, 0);
    hread(12'h140, rv); check("R11 unmapped past RAM", rv, 0);
    hread(12'h0FC, rv); check("R11 unmapped below RAM", rv, 0);

    // R6: co-processor writes dropped while held in reset
    cwrite(A_TOHOST, 32'h7);
    hread(A_TOHOST, rv); check("R6 tohost unchanged", rv, 0);
    cwrite(msg_addr(3), 32'hAA);
    hread(msg_addr(3), rv); check("R6 msg unchanged", rv, 0);
    hwrite(msg_addr(3), 32'h55);
    cread(msg_addr(3), rv); check("R6 cp read works", rv, 32'h55);
    hwrite(msg_addr(3), 32'h0);

    // R3: control register sweep
    for (int v = 0; v < 8; v++) begin
      hwrite(A_CTRL, 32'hFFFF_FE00 | 32'(v));
      hread(A_CTRL, rv); check("R3 ctrl read", rv, 32'(v) & 32'h5);
      check("R3 cp_reset", 32'(cp_reset), 32'(v & 1));
      check("R3 cp_clk_gate", 32'(cp_clk_gate), 32'((v >> 2) & 1));
    end
    hwrite(A_CTRL, 32'h0);

    // R4: both directions through the message RAM
    for (int i = 0; i < MSG_WORDS; i++) begin
      hwrite(msg_addr(i), 32'(i) * 32'h0101_0101 + 32'h100);
      cread(msg_addr(i), rv); check("R4 host->cp", rv, 32'(i) * 32'h0101_0101 + 32'h100);
    end
    for (int i = 0; i < MSG_WORDS; i++) begin
      cwrite(msg_addr(i), ~(32'(i) * 32'h0101_0101 + 32'h100));
      hread(msg_addr(i), rv); check("R4 cp->host", rv, ~(32'(i) * 32'h0101_0101 + 32'h100));
    end

    // R7: doorbell
    hwrite(A_TOCP, 32'h1);
    check("R7 doorbell set", 32'(doorbell_pending), 1);
    cwrite(A_TOCP, 32'h0);
    check("R7 doorbell clear", 32'(doorbell_pending), 0);
    cwrite(A_TOCP, 32'h8000_0000);
    check("R7 doorbell msb", 32'(doorbell_pending), 1);
    hwrite(A_TOCP, 32'h0);
    cwrite(A_TOHOST, 32'h1);
    hread(A_TOHOST, rv); check("R7 result code", rv, 1);
    hwrite(A_TOHOST, 32'h0);

    // R5: same-cycle collisions
    bothwrite(A_TOHOST, 32'h8000_0004, 32'h1);
    hread(A_TOHOST, rv); check("R5 mailbox collision", rv, 32'h8000_0004);
    bothwrite(msg_addr(2), 32'hCAFE_0001, 32'hBEEF_0002);
    cread(msg_addr(2), rv); check("R5 ram collision", rv, 32'hCAFE_0001);
    hwrite(A_TOHOST, 32'h0);

    // R8: checksum sweep with wraparound
    for (int k = 0; k < 8; k++) begin
      logic [31:0] w3, s;
      w3 = 32'hFFFF_FFF0 + 32'(k);
      s = 32'd1 + 32'(k) + 32'd1 + w3 + 32'(k & 1);
      hwrite(msg_addr(0), 32'd1);
      hwrite(msg_addr(1), 32'(k));
      hwrite(msg_addr(2), 32'd1);
      hwrite(msg_addr(3), w3);
      hwrite(msg_addr(4), s);
      check("R8 checksum", 32'(cmd_checksum_ok), 32'((k & 1) == 0));
    end

    // R9: location type sweep
    hwrite(msg_addr(0), 32'd2);
    for (int t = 0; t < 16; t++) begin
      hwrite(msg_addr(3), {4'(t), 28'h0123456});
      check("R9 loc fatal", 32'(resp_loc_fatal), 32'(t > 1));
    end
    hwrite(msg_addr(0), 32'd1);
    check("R9 command not checked", 32'(resp_loc_fatal), 0);

    // R10: start-up sequence
    hwrite(A_CTRL, 32'h5);
    hwrite(A_TOCP, 32'h3);
    hwrite(A_TOHOST, 32'h9);
    @(negedge clk); h_wr = 1; h_addr = A_CTRL; h_wdata = 32'h105;
    @(negedge clk); h_wdata = 32'h4;  // must be ignored while busy
    check("R10 edge1 doorbell", 32'(doorbell_pending), 1);
    check("R10 edge1 gate", 32'(cp_clk_gate), 1);
    check("R10 edge1 reset", 32'(cp_reset), 1);
    @(negedge clk); h_wr = 0;
    check("R10 edge2 mailbox cleared", 32'(doorbell_pending), 0);
    check("R10 edge2 gate", 32'(cp_clk_gate), 1);
    check("R10 edge2 reset", 32'(cp_reset), 1);
    @(negedge clk);
    check("R10 edge3 gate", 32'(cp_clk_gate), 0);
    check("R10 edge3 reset", 32'(cp_reset), 1);
    @(negedge clk);
    check("R10 edge4 reset", 32'(cp_reset), 0);
    hread(A_TOHOST, rv); check("R10 tohost cleared", rv, 0);
    hread(A_CTRL, rv);   check("R10 ctrl final", rv, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule